// File: doc/BRIEF.md
# Character LCD command decoder

This block interprets the host side of a dot-matrix character display controller. Each transfer comes with a register-select bit, a read/write bit and an 8-bit data bus. An accepted write is marked by a one-cycle strobe. Instruction writes update the configuration flags, the address counter and its target RAM, or the horizontal scroll quantity. Data transfers produce a read or write request toward the display RAMs, and the address counter then advances.

The block stores an extension bit, written by the function-set command, that picks between two pages of commands. The same opcode byte can therefore load a different register, with a different field layout, depending on that bit. Every accepted command makes the block busy for a number of oscillator-enable ticks set by a parameter. While it is busy, only the status read is served.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After reset, the extension bit, shift-enable, reverse and blink flags are 0, the 8-bit-bus flag is 1, the two-line flag is 0, the address counter is 0, the RAM select is DDRAM (code 00), the scroll quantity is 0 and busy is 0.
- R2: A command byte 001 d n 0 s v (rs=0, rw=0) sets bus8=d, two_line=n and ext=0, and it sets shift_en=s and reverse=v. It leaves blink unchanged.
- R3: A command byte 001 d n 1 b x sets bus8=d, two_line=n, ext=1 and blink=b. It leaves shift_en and reverse unchanged.
- R4: With ext=0, a command byte 01aaaaaa loads the 6-bit value into the address counter and selects CGRAM (code 01).
- R5: With ext=1, a command byte 01xxaaaa loads the 4-bit value from bits 3..0 into the address counter and selects SEGRAM (code 10). Bits 5..4 have no effect.
- R6: With ext=0, a command byte 1aaaaaaa loads the 7-bit address and selects DDRAM.
- R7: With ext=1, a command byte 1xqqqqqq loads bits 5..0 into the scroll quantity. Bit 6, the address counter and the RAM select are unchanged.
- R8: When rs=0, db_out shows busy on bit 7 and the address counter on bits 6..0 at all times, with no busy time. When rs=1, db_out passes ram_rdata.
- R9: A data write (rs=1, rw=0) or data read (rs=1, rw=1) pulses ram_we or ram_re in the strobe cycle, with ram_addr equal to the address counter and ram_wdata equal to the bus. The counter then increments and wraps within 7 bits for DDRAM, 6 bits for CGRAM and 4 bits for SEGRAM.
- R10: An accepted command makes busy 1 from the next cycle. Busy stays 1 for BUSY_CMD oscillator ticks, or for BUSY_DATA ticks after a data transfer, and falls on the clock edge of the last tick.
- R11: While busy, any strobed instruction or data transfer is ignored: no RAM request is made and no state changes.
- R12: A command byte 000xxxxx changes nothing and does not make the block busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| osc_tick | input | 1 | Oscillator enable, one tick per busy-time unit |
| strobe | input | 1 | One-cycle transfer strobe |
| rs | input | 1 | Register select: 0 instruction/status, 1 data |
| rw | input | 1 | 1 read, 0 write |
| db_in | input | 8 | Host bus write value |
| db_out | output | 8 | Host bus read value |
| ram_rdata | input | 8 | Data returned from the selected RAM |
| ram_we | output | 1 | RAM write request |
| ram_re | output | 1 | RAM read request |
| ram_sel | output | 2 | Target RAM: 00 DDRAM, 01 CGRAM, 10 SEGRAM |
| ram_addr | output | 7 | RAM address (address counter) |
| ram_wdata | output | 8 | RAM write data |
| bus8 | output | 1 | 8-bit bus mode flag |
| two_line | output | 1 | Two-line display flag |
| ext | output | 1 | Extension bit selecting the command page |
| shift_en | output | 1 | Display shift enabled (0: dot scroll) |
| reverse | output | 1 | Reversed display |
| blink | output | 1 | CGRAM/SEGRAM blink enable |
| scroll_qty | output | 6 | Horizontal dot-scroll quantity |
| busy | output | 1 | Busy flag |

## Verification
Directed sequences send the same opcode bytes 0x45 and 0x9A before and after the extension bit is toggled. This shows whether the decoder picks CGRAM versus SEGRAM addressing and DDRAM addressing versus the scroll quantity, and whether the ignored bits really are ignored. Data writes at the top address of each RAM separate the three wrap widths. Random mixes of commands, data transfers and status reads are issued at random tick spacing, so many land while the block is busy. These show whether a busy write is dropped, and whether the busy time of each command class ends on the right tick.

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder #(
  parameter int BUSY_CMD  = 11,
  parameter int BUSY_DATA = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       strobe,
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] db_in,
  output logic [7:0] db_out,
  input  logic [7:0] ram_rdata,
  output logic       ram_we,
  output logic       ram_re,
  output logic [1:0] ram_sel,
  output logic [6:0] ram_addr,
  output logic [7:0] ram_wdata,
  output logic       bus8,
  output logic       two_line,
  output logic       ext,
  output logic       shift_en,
  output logic       reverse,
  output logic       blink,
  output logic [5:0] scroll_qty,
  output logic       busy
);
  localparam int BMAX  = (BUSY_CMD > BUSY_DATA) ? BUSY_CMD : BUSY_DATA;
  localparam int CNT_W = $clog2(BMAX + 1);
  localparam logic [1:0] SEL_DD = 2'b00, SEL_CG = 2'b01, SEL_SEG = 2'b10;

  logic [6:0]       ac, ac_inc;
  logic [CNT_W-1:0] cnt;
  logic             free, data_go, cmd_go, accept;

  assign free    = strobe & ~busy;
  assign data_go = free & rs;
  assign cmd_go  = free & ~rs & ~rw & (|db_in[7:5]);
  assign accept  = data_go | cmd_go;

  assign ram_we    = data_go & ~rw;
  assign ram_re    = data_go & rw;
  assign ram_addr  = ac;
  assign ram_wdata = db_in;
  assign db_out    = rs ? ram_rdata : {busy, ac};

  always_comb begin
    case (ram_sel)
      SEL_CG:  ac_inc = {1'b0, ac[5:0] + 6'd1};
      SEL_SEG: ac_inc = {3'b0, ac[3:0] + 4'd1};
      default: ac_inc = ac + 7'd1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac <= '0; ram_sel <= SEL_DD; scroll_qty <= '0;
      bus8 <= 1'b1; two_line <= 1'b0; ext <= 1'b0;
      shift_en <= 1'b0; reverse <= 1'b0; blink <= 1'b0;
    end else if (data_go) begin
      ac <= ac_inc;
    end else if (cmd_go) begin
      if (db_in[7]) begin
        if (ext) scroll_qty <= db_in[5:0];
        else begin ac <= db_in[6:0]; ram_sel <= SEL_DD; end
      end else if (db_in[6]) begin
        if (ext) begin ac <= {3'b0, db_in[3:0]}; ram_sel <= SEL_SEG; end
        else     begin ac <= {1'b0, db_in[5:0]}; ram_sel <= SEL_CG;  end
      end else begin
        bus8 <= db_in[4]; two_line <= db_in[3]; ext <= db_in[2];
        if (db_in[2]) blink <= db_in[1];
        else begin shift_en <= db_in[1]; reverse <= db_in[0]; end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= rs ? CNT_W'(BUSY_DATA) : CNT_W'(BUSY_CMD);
    end else if (busy && osc_tick) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) busy <= 1'b0;
    end
  end

  assert_busy_after_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !busy && rs) |=> busy);
  assert_busy_ends_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(osc_tick));
  assert_no_ram_access_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(ram_we || ram_re));
  assert_state_frozen_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ac) && $stable(ram_sel) && $stable(ext) && $stable(scroll_qty)));
  assert_cg_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel == SEL_CG) |-> !ram_addr[6]);
  assert_seg_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel == SEL_SEG) |-> (ram_addr[6:4] == 3'b0));
  assert_sel_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel != 2'b11);
  assert_status_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rs |-> (db_out[7] == busy));
endmodule

// File: tb/test_lcd_cmd_decoder.sv
module test_lcd_cmd_decoder;
  localparam int TC = 11, TD = 12;
  logic clk = 0, rst_n = 0, osc_tick = 0, strobe = 0, rs = 0, rw = 0;
  logic [7:0] db_in = 0, ram_rdata = 0, db_out, ram_wdata;
  logic ram_we, ram_re, bus8, two_line, ext, shift_en, reverse, blink, busy;
  logic [1:0] ram_sel;
  logic [6:0] ram_addr;
  logic [5:0] scroll_qty;

  lcd_cmd_decoder #(.BUSY_CMD(TC), .BUSY_DATA(TD)) i_lcd_cmd_decoder (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [6:0] m_ac; logic [1:0] m_sel; logic [5:0] m_scr;
  logic m_b8, m_n, m_ext, m_sh, m_rev, m_bl;
  int m_left;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk(req, ram_addr, m_ac);   chk(req, ram_sel, m_sel);
    chk(req, scroll_qty, m_scr); chk(req, bus8, m_b8);
    chk(req, two_line, m_n);    chk(req, ext, m_ext);
    chk(req, shift_en, m_sh);   chk(req, reverse, m_rev);
    chk(req, blink, m_bl);      chk(req, busy, m_left != 0);
  endtask

  function automatic string tag_of(logic r, logic w, logic [7:0] d, logic e);
    if (m_left != 0) return "R11";
    if (r) return "R9";
    if (w) return "R8";
    if (d[7]) return e ? "R7" : "R6";
    if (d[6]) return e ? "R5" : "R4";
    if (d[5]) return d[2] ? "R3" : "R2";
    return "R12";
  endfunction

  function automatic logic [6:0] wrap_inc(logic [6:0] a, logic [1:0] s);
    if (s == 2'b01) return {1'b0, a[5:0] + 6'd1};
    if (s == 2'b10) return {3'b0, a[3:0] + 4'd1};
    return a + 7'd1;
  endfunction

  task automatic op(logic r, logic w, logic [7:0] d);
    string t;
    logic [7:0] rd;
    t = tag_of(r, w, d, m_ext);
    rd = 8'($urandom);
    @(negedge clk);
    rs = r; rw = w; db_in = d; ram_rdata = rd; strobe = 1;
    #1;
    chk(t, ram_we, (m_left == 0) && r && !w);
    chk(t, ram_re, (m_left == 0) && r && w);
    chk("R8", db_out, r ? rd : {m_left != 0, m_ac});
    if (m_left == 0 && r) begin
      chk("R9", ram_addr, m_ac);
      chk("R9", ram_sel, m_sel);
      if (!w) chk("R9", ram_wdata, d);
    end
    @(negedge clk);
    strobe = 0;
    if (m_left == 0) begin
      if (r) begin m_ac = wrap_inc(m_ac, m_sel); m_left = TD; end
      else if (!w && d[7:5] != 3'b000) begin
        m_left = TC;
        if (d[7]) begin
          if (m_ext) m_scr = d[5:0]; else begin m_ac = d[6:0]; m_sel = 2'b00; end
        end else if (d[6]) begin
          if (m_ext) begin m_ac = {3'b0, d[3:0]}; m_sel = 2'b10; end
          else begin m_ac = {1'b0, d[5:0]}; m_sel = 2'b01; end
        end else begin
          m_b8 = d[4]; m_n = d[3]; m_ext = d[2];
          if (d[2]) m_bl = d[1]; else begin m_sh = d[1]; m_rev = d[0]; end
        end
      end
    end
    compare_all(t);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1;
      @(negedge clk); osc_tick = 0;
      if (m_left > 0) m_left--;
      chk("R10", busy, m_left != 0);
    end
  endtask

  task automatic idle_op(logic r, logic w, logic [7:0] d);
    op(r, w, d);
    tick(TD);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_ac = 0; m_sel = 0; m_scr = 0; m_b8 = 1; m_n = 0; m_ext = 0;
    m_sh = 0; m_rev = 0; m_bl = 0; m_left = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all("R1");
    chk("R1", db_out, 8'h00);

    // same opcode with the extension bit clear, then set
    idle_op(0, 0, 8'h45);                 // R4: CGRAM 0x05
    idle_op(0, 0, 8'h9A);                 // R6: DDRAM 0x1A
    idle_op(0, 0, 8'h37);                 // R3: ext=1, blink=1
    idle_op(0, 0, 8'h75);                 // R5: SEGRAM 5, bits 5..4 ignored
    idle_op(0, 0, 8'hDA);                 // R7: scroll 0x1A, bit 6 ignored
    idle_op(0, 0, 8'h9A);                 // R7: same opcode as DDRAM load above
    idle_op(0, 0, 8'h2B);                 // R2: ext=0, shift and reverse set
    idle_op(0, 0, 8'h45);                 // R4 again after toggle
    idle_op(0, 0, 8'h0F);                 // R12: no effect

    // R9 wrap corners
    idle_op(0, 0, 8'hFF); idle_op(1, 0, 8'hA5);   // DDRAM 0x7F -> 0
    idle_op(0, 0, 8'h7F); idle_op(1, 1, 8'h00);   // CGRAM 0x3F -> 0
    idle_op(0, 0, 8'h34);
    idle_op(0, 0, 8'h4F); idle_op(1, 0, 8'h3C);   // SEGRAM 0xF -> 0
    idle_op(0, 0, 8'h30);

    // R10 exact tick counts, R11 ignored while busy
    op(0, 0, 8'h83);
    tick(TC - 1);
    op(1, 0, 8'h11);                      // R11: dropped
    op(0, 0, 8'h24);                      // R11: dropped
    op(0, 1, 8'h00);                      // R8: status while busy
    tick(1);
    op(1, 1, 8'h00);
    tick(TD);

    for (int k = 0; k < 400; k++) begin
      logic r, w;
      logic [7:0] d;
      r = ($urandom_range(0, 1) == 1);
      w = ($urandom_range(0, 3) == 0);
      d = 8'($urandom);
      if (!r && !w && $urandom_range(0, 3) == 0) d[7:5] = 3'b001;
      op(r, w, d);
      tick($urandom_range(0, 14));
    end
    tick(TD);
    finish_run();
  end
endmodule